// File: doc/BRIEF.md
# Per-Hart Debug Permission Gate

This block stands between an external debug controller and a single hart. It decides, cycle by cycle, whether debug operations may act on the hart. The decision combines a machine-level debug enable input, a submachine debug-allow configuration bit and the hart's current privilege level together with its virtualization bit. Halt requests, program-buffer runs, abstract commands and register reads or writes that do not halt the hart all pass through it.

Halt requests that arrive while debugging is forbidden are held as pending and forwarded once the hart reaches a privilege level that may be debugged. Commands are answered one cycle later with a grant or a refusal. Register accesses without halting are either forwarded with the privilege they must carry or dropped. Writes of the debug access privilege are checked, and illegal values raise a sticky security-fault code that the debugger clears with a pulse. The block also reports the highest privilege that may be debugged and tells the access path whether the modify-privilege bit and its saved privilege may take effect.

Top module: `dbg_gate`

## Requirements
- R1: With `mach_dbg_en` = 1, `dbg_allowed` is 1 at every privilege, `max_priv` = 3 (M) and `max_priv_valid` = 1.
- R2: With `mach_dbg_en` = 0 and `sub_dbg_allow` = 1, `dbg_allowed` is 1 for privileges 0 (U), 1 (S) and 2, and 0 for privilege 3 (M) with `hart_virt` = 0; `max_priv` = 1 and `max_priv_valid` = 1.
- R3: With both `mach_dbg_en` and `sub_dbg_allow` at 0, `dbg_allowed` is 0 in every mode, `max_priv_valid` = 0 and `max_priv` = 0.
- R4: A `halt_req` pulse sets a pending halt in the next cycle; `halt_issue` equals pending AND `dbg_allowed`; pending holds until a cycle where `halt_ack` and `halt_issue` are both 1, and is clear after that edge unless `halt_req` is also 1 in that cycle.
- R5: A `cmd_req` pulse gives `cmd_rsp_valid` = 1 in the next cycle, with `cmd_granted` equal to the `dbg_allowed` value of the request cycle; a refused command sets `err_code` to 6.
- R6: A `ra_req` pulse gives, in the next cycle, `ra_fwd` = 1 with `ra_priv` = 3 when `mach_dbg_en` = 1, or `ra_priv` = 1 when only `sub_dbg_allow` = 1; with both at 0 it gives `ra_drop` = 1 and `ra_fwd` = 0.
- R7: A `dap_wr` of `dap_val` is legal when the value is 3 and `mach_dbg_en` = 1, or the value is 0 or 1 and either enable is 1; a legal write shows on `dap_cur` in the next cycle, an illegal one (including value 2) leaves `dap_cur` unchanged and sets `err_code` to 6.
- R8: `err_code` keeps its value until an `err_clr` pulse sets it to 0 in the next cycle; a new fault in the same cycle as `err_clr` wins and leaves 6.
- R9: `mprv_eff` = `mprv_in` when the privilege in `mpp_in` may be debugged under R1/R2/R3, and 0 otherwise.
- R10: With `hart_virt` = 1 the hart is never treated as M: privilege 3 with `hart_virt` = 1 is debuggable when `sub_dbg_allow` = 1.
- R11: After reset, pending halt, `cmd_rsp_valid`, `ra_fwd`, `ra_drop`, `dap_cur` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mach_dbg_en | input | 1 | Machine-level debug enable |
| sub_dbg_allow | input | 1 | Submachine debug-allow configuration bit |
| hart_priv | input | 2 | Current hart privilege (0 U, 1 S, 3 M) |
| hart_virt | input | 1 | Hart runs virtualized |
| dbg_allowed | output | 1 | Debug permitted at the current privilege |
| max_priv | output | 2 | Highest debuggable privilege |
| max_priv_valid | output | 1 | Some privilege is debuggable |
| halt_req | input | 1 | Halt request pulse from the debug controller |
| halt_ack | input | 1 | Hart acknowledges a halt |
| halt_issue | output | 1 | Halt request forwarded to the hart |
| cmd_req | input | 1 | Program-buffer or abstract command request pulse |
| cmd_rsp_valid | output | 1 | Command response strobe |
| cmd_granted | output | 1 | Command allowed to run |
| ra_req | input | 1 | Register access without halting request |
| ra_fwd | output | 1 | Register access forwarded |
| ra_drop | output | 1 | Register access dropped |
| ra_priv | output | 2 | Privilege the forwarded access carries |
| dap_wr | input | 1 | Debug access privilege write strobe |
| dap_val | input | 2 | Debug access privilege write value |
| dap_cur | output | 2 | Current debug access privilege |
| err_clr | input | 1 | Error clear pulse |
| err_code | output | 3 | Sticky command error code (6 = security fault) |
| mprv_in | input | 1 | Modify-privilege bit from the hart status |
| mpp_in | input | 2 | Saved previous privilege from the hart status |
| mprv_eff | output | 1 | Modify-privilege bit allowed to act |

## Verification
The permission, maximum-privilege, halt-issue and modify-privilege outputs are combinational and due in the same cycle as their inputs; pending halt, command and register-access responses, the access privilege and the error code are due one clock edge after the request. The bench drives inputs between edges, advances its behavioural model once per rising edge from the inputs held across that edge, and compares every output a quarter period later while the same inputs are still applied, so both kinds of result are sampled in the cycle they are due. Directed passes hold a halt across a forbidden privilege and then release it, and push refused writes against a clear pulse.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
    localparam int PRIV_W = 2;
    localparam int ERR_W  = 3;

    localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_R = 2'd2;
    localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

    localparam logic [ERR_W-1:0] ERR_NONE      = 3'd0;
    localparam logic [ERR_W-1:0] ERR_SEC_FAULT = 3'd6;

    typedef struct packed {
        logic              cmd_v;
        logic              cmd_ok;
        logic              ra_fwd;
        logic              ra_drop;
        logic [PRIV_W-1:0] ra_priv;
    } rsp_t;

    typedef struct packed {
        logic [PRIV_W-1:0] dap;
        logic [ERR_W-1:0]  err;
    } stat_t;
endpackage

// File: rtl/dbg_gate_policy.sv
module dbg_gate_policy
    import dbg_gate_pkg::*;
(
    input  logic              mach_en,
    input  logic              sub_en,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic [PRIV_W-1:0] mpp,
    input  logic [PRIV_W-1:0] wr_val,
    output logic              allow_now,
    output logic              any_en,
    output logic [PRIV_W-1:0] top_priv,
    output logic              top_valid,
    output logic              mpp_ok,
    output logic              wr_legal
);
    logic in_machine;

    always_comb begin
        in_machine = (priv == PRIV_M) && !virt;
        any_en     = mach_en || sub_en;
        allow_now  = mach_en || (sub_en && !in_machine);
        mpp_ok     = mach_en || (sub_en && (mpp != PRIV_M));
        top_valid  = any_en;
        top_priv   = mach_en ? PRIV_M : (sub_en ? PRIV_S : PRIV_U);
        unique case (wr_val)
            PRIV_M:         wr_legal = mach_en;
            PRIV_U, PRIV_S: wr_legal = any_en;
            default:        wr_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_gate_halt.sv
module dbg_gate_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic halt_ack,
    input  logic allow_now,
    output logic halt_issue
);
    logic pend_d, pend_q;

    always_comb begin
        halt_issue = pend_q && allow_now;
        pend_d     = halt_req || (pend_q && !(halt_ack && halt_issue));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R4: a pending halt survives every cycle without an accepted acknowledge
    a_r4_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !(halt_ack && halt_issue) |=> pend_q);

    // R4: an accepted acknowledge with no new request retires the halt
    a_r4_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
        halt_issue && halt_ack && !halt_req |=> !pend_q);
endmodule

// File: rtl/dbg_gate_status.sv
module dbg_gate_status
    import dbg_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PRIV_W-1:0] wr_val,
    input  logic              wr_legal,
    input  logic              cmd_refused,
    input  logic              clr,
    output logic [PRIV_W-1:0] dap_cur,
    output logic [ERR_W-1:0]  err_code
);
    stat_t st_d, st_q;
    logic  fault;

    always_comb begin
        st_d  = st_q;
        fault = cmd_refused || (wr_en && !wr_legal);
        if (wr_en && wr_legal) st_d.dap = wr_val;
        if (fault)             st_d.err = ERR_SEC_FAULT;
        else if (clr)          st_d.err = ERR_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dap_cur  = st_q.dap;
    assign err_code = st_q.err;

    // R7: a refused write keeps the old privilege and raises the fault code
    a_r7_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_legal |=> dap_cur == $past(dap_cur) && err_code == ERR_SEC_FAULT);

    // R8: the error code holds until a clear pulse
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != ERR_NONE && !clr |=> err_code == $past(err_code));
endmodule

// File: rtl/dbg_gate.sv
module dbg_gate
    import dbg_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mach_dbg_en,
    input  logic              sub_dbg_allow,
    input  logic [PRIV_W-1:0] hart_priv,
    input  logic              hart_virt,
    output logic              dbg_allowed,
    output logic [PRIV_W-1:0] max_priv,
    output logic              max_priv_valid,
    input  logic              halt_req,
    input  logic              halt_ack,
    output logic              halt_issue,
    input  logic              cmd_req,
    output logic              cmd_rsp_valid,
    output logic              cmd_granted,
    input  logic              ra_req,
    output logic              ra_fwd,
    output logic              ra_drop,
    output logic [PRIV_W-1:0] ra_priv,
    input  logic              dap_wr,
    input  logic [PRIV_W-1:0] dap_val,
    output logic [PRIV_W-1:0] dap_cur,
    input  logic              err_clr,
    output logic [ERR_W-1:0]  err_code,
    input  logic              mprv_in,
    input  logic [PRIV_W-1:0] mpp_in,
    output logic              mprv_eff
);
    logic any_en, mpp_ok, wr_legal;
    rsp_t rsp_d, rsp_q;

    dbg_gate_policy u_policy (
        .mach_en   (mach_dbg_en),
        .sub_en    (sub_dbg_allow),
        .priv      (hart_priv),
        .virt      (hart_virt),
        .mpp       (mpp_in),
        .wr_val    (dap_val),
        .allow_now (dbg_allowed),
        .any_en    (any_en),
        .top_priv  (max_priv),
        .top_valid (max_priv_valid),
        .mpp_ok    (mpp_ok),
        .wr_legal  (wr_legal)
    );

    dbg_gate_halt u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .halt_ack   (halt_ack),
        .allow_now  (dbg_allowed),
        .halt_issue (halt_issue)
    );

    dbg_gate_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (dap_wr),
        .wr_val      (dap_val),
        .wr_legal    (wr_legal),
        .cmd_refused (cmd_req && !dbg_allowed),
        .clr         (err_clr),
        .dap_cur     (dap_cur),
        .err_code    (err_code)
    );

    always_comb begin
        rsp_d         = '0;
        rsp_d.cmd_v   = cmd_req;
        rsp_d.cmd_ok  = cmd_req && dbg_allowed;
        rsp_d.ra_fwd  = ra_req && any_en;
        rsp_d.ra_drop = ra_req && !any_en;
        if (ra_req && any_en) rsp_d.ra_priv = mach_dbg_en ? PRIV_M : PRIV_S;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign cmd_rsp_valid = rsp_q.cmd_v;
    assign cmd_granted   = rsp_q.cmd_ok;
    assign ra_fwd        = rsp_q.ra_fwd;
    assign ra_drop       = rsp_q.ra_drop;
    assign ra_priv       = rsp_q.ra_priv;
    assign mprv_eff      = mprv_in && mpp_ok;

    // R1: the machine enable opens every level up to M
    a_r1_all_levels: assert property (@(posedge clk) disable iff (!rst_n)
        mach_dbg_en |-> dbg_allowed && max_priv == PRIV_M && max_priv_valid);

    // R2: submachine allow alone never opens unvirtualized M
    a_r2_no_machine: assert property (@(posedge clk) disable iff (!rst_n)
        !mach_dbg_en && sub_dbg_allow && hart_priv == PRIV_M && !hart_virt |-> !dbg_allowed);

    // R3: with both controls off nothing is debuggable
    a_r3_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !mach_dbg_en && !sub_dbg_allow |-> !dbg_allowed && !max_priv_valid && !halt_issue);

    // R5: every command is answered in the next cycle
    a_r5_answer: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> cmd_rsp_valid);

    // R6: with both controls off a non-halting access is dropped
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ra_req && !mach_dbg_en && !sub_dbg_allow |=> ra_drop && !ra_fwd);

    // R6: forward and drop never coincide
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ra_fwd && ra_drop));
endmodule

// File: tb/dbg_gate_bench.sv
module dbg_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mach_dbg_en = 0, sub_dbg_allow = 0, hart_virt = 0;
    logic [1:0] hart_priv = 0;
    logic       halt_req = 0, halt_ack = 0, cmd_req = 0, ra_req = 0;
    logic       dap_wr = 0, err_clr = 0, mprv_in = 0;
    logic [1:0] dap_val = 0, mpp_in = 0;
    logic       dbg_allowed, max_priv_valid, halt_issue, cmd_rsp_valid, cmd_granted;
    logic       ra_fwd, ra_drop, mprv_eff;
    logic [1:0] max_priv, ra_priv, dap_cur;
    logic [2:0] err_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    bit       m_pend, m_cv, m_cok, m_rf, m_rd;
    int       m_rp, m_dap, m_err;

    always #10 clk = ~clk;

    dbg_gate u_dbg_gate (
        .clk(clk), .rst_n(rst_n),
        .mach_dbg_en(mach_dbg_en), .sub_dbg_allow(sub_dbg_allow),
        .hart_priv(hart_priv), .hart_virt(hart_virt),
        .dbg_allowed(dbg_allowed), .max_priv(max_priv), .max_priv_valid(max_priv_valid),
        .halt_req(halt_req), .halt_ack(halt_ack), .halt_issue(halt_issue),
        .cmd_req(cmd_req), .cmd_rsp_valid(cmd_rsp_valid), .cmd_granted(cmd_granted),
        .ra_req(ra_req), .ra_fwd(ra_fwd), .ra_drop(ra_drop), .ra_priv(ra_priv),
        .dap_wr(dap_wr), .dap_val(dap_val), .dap_cur(dap_cur),
        .err_clr(err_clr), .err_code(err_code),
        .mprv_in(mprv_in), .mpp_in(mpp_in), .mprv_eff(mprv_eff)
    );

    function automatic bit can_debug(int p, bit v);
        if (mach_dbg_en) return 1;
        if (!sub_dbg_allow) return 0;
        return !(p == 3 && !v);
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        string ptag;
        if (hart_virt && hart_priv == 2'd3) ptag = "R10";
        else if (mach_dbg_en) ptag = "R1";
        else if (sub_dbg_allow) ptag = "R2";
        else ptag = "R3";
        check({ptag, " dbg_allowed"}, dbg_allowed, can_debug(hart_priv, hart_virt));
        check("R1/R2/R3 max_priv_valid", max_priv_valid, mach_dbg_en | sub_dbg_allow);
        check("R1/R2/R3 max_priv", max_priv,
              mach_dbg_en ? 3 : (sub_dbg_allow ? 1 : 0));
        check("R4 halt_issue", halt_issue, m_pend && can_debug(hart_priv, hart_virt));
        check("R5 cmd_rsp_valid", cmd_rsp_valid, m_cv);
        check("R5 cmd_granted", cmd_granted, m_cok);
        check("R6 ra_fwd", ra_fwd, m_rf);
        check("R6 ra_drop", ra_drop, m_rd);
        check("R6 ra_priv", ra_priv, m_rp);
        check("R7 dap_cur", dap_cur, m_dap);
        check("R8 err_code", err_code, m_err);
        check("R9 mprv_eff", mprv_eff, mprv_in && can_debug(mpp_in, 1'b0));
    endtask

    // one clock: model advances from inputs held across the edge, then compare
    task automatic step();
        bit allow, legal, fault, issue;
        allow = can_debug(hart_priv, hart_virt);
        issue = m_pend && allow;
        if (dap_val == 2'd3) legal = mach_dbg_en;
        else if (dap_val == 2'd2) legal = 0;
        else legal = mach_dbg_en | sub_dbg_allow;
        fault = (cmd_req && !allow) || (dap_wr && !legal);
        @(posedge clk);
        m_pend = halt_req || (m_pend && !(halt_ack && issue));
        m_cv   = cmd_req;
        m_cok  = cmd_req && allow;
        m_rf   = ra_req && (mach_dbg_en || sub_dbg_allow);
        m_rd   = ra_req && !(mach_dbg_en || sub_dbg_allow);
        m_rp   = m_rf ? (mach_dbg_en ? 3 : 1) : 0;
        if (dap_wr && legal) m_dap = dap_val;
        if (fault) m_err = 6;
        else if (err_clr) m_err = 0;
        #5;
        compare_all();
    endtask

    task automatic pulses_off();
        halt_req = 0; halt_ack = 0; cmd_req = 0; ra_req = 0; dap_wr = 0; err_clr = 0;
    endtask

    initial begin
        #5000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #5 rst_n = 1;
        #1;
        // R11: reset state
        check("R11 pending halt", halt_issue, 0);
        check("R11 cmd_rsp_valid", cmd_rsp_valid, 0);
        check("R11 ra_fwd", ra_fwd, 0);
        check("R11 ra_drop", ra_drop, 0);
        check("R11 dap_cur", dap_cur, 0);
        check("R11 err_code", err_code, 0);
        #4;

        // directed R4: halt held in M with only submachine allow, released in S
        sub_dbg_allow = 1; hart_priv = 3; halt_req = 1;
        step(); halt_req = 0;
        repeat (3) step();
        check("R4 held while M", halt_issue, 0);
        hart_priv = 1; #1;
        check("R4 released in S", halt_issue, 1);
        halt_ack = 1; step(); halt_ack = 0;
        step();
        check("R4 cleared after ack", halt_issue, 0);

        // directed R7/R8: M write refused, clear and fault collide
        dap_wr = 1; dap_val = 3; step(); pulses_off();
        check("R7 refused M write", err_code, 6);
        err_clr = 1; dap_wr = 1; dap_val = 2; step(); pulses_off();
        check("R8 fault beats clear", err_code, 6);
        err_clr = 1; step(); pulses_off();
        check("R8 clear", err_code, 0);
        dap_wr = 1; dap_val = 1; step(); pulses_off();
        check("R7 legal S write", dap_cur, 1);

        // directed R10: virtual M with submachine allow is debuggable
        hart_priv = 3; hart_virt = 1; #1;
        check("R10 virt M allowed", dbg_allowed, 1);
        hart_virt = 0; #1;
        check("R2 real M refused", dbg_allowed, 0);

        // randomized sweep, every output compared each cycle
        for (int i = 0; i < 3000; i++) begin
            if (i % 40 == 0) begin
                mach_dbg_en   = ($urandom % 3) == 0;
                sub_dbg_allow = $urandom % 2;
            end
            hart_priv = 2'($urandom % 4);
            hart_virt = ($urandom % 4) == 0;
            halt_req  = ($urandom % 6) == 0;
            halt_ack  = ($urandom % 3) == 0;
            cmd_req   = ($urandom % 4) == 0;
            ra_req    = ($urandom % 4) == 0;
            dap_wr    = ($urandom % 5) == 0;
            dap_val   = 2'($urandom % 4);
            err_clr   = ($urandom % 6) == 0;
            mprv_in   = $urandom % 2;
            mpp_in    = 2'($urandom % 4);
            step();
        end
        pulses_off();
        step();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule